// File: doc/BRIEF.md
# Banked Memory Address Decoder

This block turns the upper bits of a 20-bit address into active-low chip enables for a small system built from 512K RAM devices, a boot ROM, a memory-mapped device window and four 128K banked RAM devices. The enables are combinational in the current address, so a chip is selected in the same cycle that its address is presented. Only memory cycles select memory. An I/O cycle selects nothing, and so does an idle bus.

Two small registers shape the map. A bank register picks which of the four banked chips answers in the 80000h–9FFFFh window. A high-RAM enable bit decides whether the C0000h–DFFFFh region and the B0000h–BFFFFh gap go to RAM or stay with the ROM and the hole. Software loads both registers with I/O writes to two fixed port numbers. Reset clears both, so the machine starts with bank chip 0 mapped and the upper region given to ROM. The decode is ordered by priority: the ROM wins first, then the bank window, then the device window, and a default RAM select applies only where none of those claims the address. The lowest 1K (the interrupt vector table) always stays in unbanked low RAM.

The data pins are plain control inputs. No stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `memmap_bank_decode`

## Requirements
- R1: All enables are active-low. All of them are high (inactive) when `cyc` is low, and on any I/O cycle (`cyc`=1, `is_mem`=0).
- R2: A memory cycle with address below 80000h asserts `ram_lo_n` only. The bank register has no effect here, including on addresses 00000h–003FFh.
- R3: A memory cycle at E0000h–FFFFFh asserts `rom_n` only, whatever the high-RAM bit holds.
- R4: A memory cycle at 80000h–9FFFFh asserts only `bank_n[k]`, where k = {B,A}. A is bank register bit 0 and B is bank register bit 1.
- R5: A memory cycle at A0000h–AFFFFh asserts `dev_n` only.
- R6: When the high-RAM bit is 0, C0000h–DFFFFh asserts `rom_n` and B0000h–BFFFFh asserts nothing. When the bit is 1, both ranges assert `ram_hi_n`.
- R7: An I/O write (`cyc`=1, `is_mem`=0, `wr`=1) whose address bits [15:0] equal 00F0h loads the bank register from `wdata[1:0]`. The new value is used starting in the next cycle. I/O reads, writes to other ports, and memory writes leave the register unchanged.
- R8: An I/O write whose address bits [15:0] equal 00F1h loads the high-RAM bit from `wdata[0]`, effective in the next cycle.
- R9: Reset (`rst_n` low) clears the bank register to 0 and the high-RAM bit to 0.
- R10: At most one enable is low in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the two map registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc | input | 1 | Bus cycle in progress, address valid |
| is_mem | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| wr | input | 1 | Write cycle |
| addr | input | 20 | Bus address; bits [15:0] give the port number on I/O cycles |
| wdata | input | 2 | Data bits sampled on map-register writes |
| ram_lo_n | output | 1 | Low RAM enable (00000h–7FFFFh) |
| ram_hi_n | output | 1 | High RAM enable (gap and C0000h–DFFFFh when enabled) |
| rom_n | output | 1 | ROM enable |
| dev_n | output | 1 | Memory-mapped device window enable |
| bank_n | output | 4 | Banked RAM chip enables, one per bank |

## Verification
Two functions can fall in the same cycle. A register-loading I/O write is decoded for enables (all of which must stay high) in the same cycle that it changes the bank or high-RAM register. The access that follows it on the very next cycle must already see the new mapping. The bench provokes this by issuing each port write and then, without any gap, sweeping every 64K block at three offsets under all eight register settings. It compares every enable vector against a map computed from address ranges, and it counts the active enables to confirm that no more than one is low.

// File: rtl/mbd_pkg.sv
package mbd_pkg;
  typedef enum logic [2:0] {
    RG_NONE = 3'd0,
    RG_LO   = 3'd1,
    RG_ROM  = 3'd2,
    RG_BANK = 3'd3,
    RG_DEV  = 3'd4,
    RG_HI   = 3'd5
  } region_t;

  localparam int unsigned TOP_BITS = 4;
endpackage

// File: rtl/mbd_port_latch.sv
module mbd_port_latch #(
  parameter int unsigned PORT_W     = 16,
  parameter int unsigned BANK_W     = 2,
  parameter logic [15:0] BANK_PORT  = 16'h00F0,
  parameter logic [15:0] HIRAM_PORT = 16'h00F1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr,
  input  logic [PORT_W-1:0] port,
  input  logic [BANK_W-1:0] wdata,
  output logic [BANK_W-1:0] bank_sel,
  output logic              hiram_en
);
  localparam logic [PORT_W-1:0] BANK_ADR  = PORT_W'(BANK_PORT);
  localparam logic [PORT_W-1:0] HIRAM_ADR = PORT_W'(HIRAM_PORT);

  logic hit_bank, hit_hiram;
  assign hit_bank  = io_wr && (port == BANK_ADR);
  assign hit_hiram = io_wr && (port == HIRAM_ADR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_sel <= '0;
      hiram_en <= 1'b0;
    end else begin
      if (hit_bank)  bank_sel <= wdata;
      if (hit_hiram) hiram_en <= wdata[0];
    end
  end
endmodule

// File: rtl/mbd_region.sv
module mbd_region
  import mbd_pkg::*;
(
  input  logic [TOP_BITS-1:0] top,
  input  logic                hiram_en,
  output region_t             region
);
  // Priority: low RAM / ROM / bank window / device / default high RAM.
  always_comb begin
    if (!top[3])                    region = RG_LO;
    else if (top[3:1] == 3'b111)    region = RG_ROM;
    else if (top[3:1] == 3'b100)    region = RG_BANK;
    else if (!top[2] && !top[0])    region = RG_DEV;
    else if (hiram_en)              region = RG_HI;
    else if (top[2])                region = RG_ROM;
    else                            region = RG_NONE;
  end
endmodule

// File: rtl/mbd_enable.sv
module mbd_enable
  import mbd_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned BANK_W    = 2
) (
  input  logic                 active,
  input  region_t              region,
  input  logic [BANK_W-1:0]    bank_sel,
  output logic                 ram_lo_n,
  output logic                 ram_hi_n,
  output logic                 rom_n,
  output logic                 dev_n,
  output logic [NUM_BANKS-1:0] bank_n
);
  assign ram_lo_n = !(active && region == RG_LO);
  assign ram_hi_n = !(active && region == RG_HI);
  assign rom_n    = !(active && region == RG_ROM);
  assign dev_n    = !(active && region == RG_DEV);

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    assign bank_n[i] = !(active && region == RG_BANK && bank_sel == BANK_W'(i));
  end
endmodule

// File: rtl/memmap_bank_decode.sv
module memmap_bank_decode
  import mbd_pkg::*;
#(
  parameter int unsigned ADDR_W     = 20,
  parameter int unsigned PORT_W     = 16,
  parameter int unsigned NUM_BANKS  = 4,
  parameter logic [15:0] BANK_PORT  = 16'h00F0,
  parameter logic [15:0] HIRAM_PORT = 16'h00F1,
  localparam int unsigned BANK_W    = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cyc,
  input  logic                 is_mem,
  input  logic                 wr,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [BANK_W-1:0]    wdata,
  output logic                 ram_lo_n,
  output logic                 ram_hi_n,
  output logic                 rom_n,
  output logic                 dev_n,
  output logic [NUM_BANKS-1:0] bank_n
);
  logic [BANK_W-1:0] bank_sel;
  logic              hiram_en;
  logic              io_wr;
  region_t           region;

  assign io_wr = cyc && !is_mem && wr;

  mbd_port_latch #(
    .PORT_W(PORT_W), .BANK_W(BANK_W),
    .BANK_PORT(BANK_PORT), .HIRAM_PORT(HIRAM_PORT)
  ) u_latch (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr),
    .port(addr[PORT_W-1:0]), .wdata(wdata),
    .bank_sel(bank_sel), .hiram_en(hiram_en)
  );

  mbd_region u_region (
    .top(addr[ADDR_W-1 -: TOP_BITS]), .hiram_en(hiram_en), .region(region)
  );

  mbd_enable #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_enable (
    .active(cyc && is_mem), .region(region), .bank_sel(bank_sel),
    .ram_lo_n(ram_lo_n), .ram_hi_n(ram_hi_n), .rom_n(rom_n),
    .dev_n(dev_n), .bank_n(bank_n)
  );
endmodule

// File: rtl/memmap_bank_decode_chk.sv
module memmap_bank_decode_chk #(
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned BANK_W    = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cyc,
  input logic                 is_mem,
  input logic                 wr,
  input logic [ADDR_W-1:0]    addr,
  input logic [BANK_W-1:0]    wdata,
  input logic                 ram_lo_n,
  input logic                 ram_hi_n,
  input logic                 rom_n,
  input logic                 dev_n,
  input logic [NUM_BANKS-1:0] bank_n,
  input logic [BANK_W-1:0]    bank_sel,
  input logic                 hiram_en
);
  logic [NUM_BANKS+3:0] act;
  assign act = ~{ram_lo_n, ram_hi_n, rom_n, dev_n, bank_n};

  logic mem_on;
  assign mem_on = cyc && is_mem;

  assert_one_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(act) <= 1);

  assert_io_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_on) |-> (act == '0));

  assert_low_ram_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_on && !addr[ADDR_W-1]) |-> !ram_lo_n);

  assert_rom_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_on && addr[ADDR_W-1 -: 3] == 3'b111) |-> !rom_n);

  assert_bank_pick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_on && addr[ADDR_W-1 -: 3] == 3'b100) |-> (bank_n[bank_sel] == 1'b0));

  assert_hiram_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_on && addr[ADDR_W-1 -: 3] == 3'b110 && !hiram_en) |-> !rom_n);

  assert_bank_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc && !is_mem && wr && addr[15:0] == 16'h00F0) |=> (bank_sel == $past(wdata)));

  assert_hiram_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc && !is_mem && wr && addr[15:0] == 16'h00F1) |=> (hiram_en == $past(wdata[0])));
endmodule

bind memmap_bank_decode memmap_bank_decode_chk #(
  .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cyc(cyc), .is_mem(is_mem), .wr(wr),
  .addr(addr), .wdata(wdata), .ram_lo_n(ram_lo_n), .ram_hi_n(ram_hi_n),
  .rom_n(rom_n), .dev_n(dev_n), .bank_n(bank_n),
  .bank_sel(bank_sel), .hiram_en(hiram_en)
);

// File: tb/sim_memmap_bank_decode.sv
`timescale 1ns/1ps
module sim_memmap_bank_decode;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc = 1'b0, is_mem = 1'b0, wr = 1'b0;
  logic [19:0] addr = '0;
  logic [1:0]  wdata = '0;
  logic ram_lo_n, ram_hi_n, rom_n, dev_n;
  logic [3:0] bank_n;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  memmap_bank_decode u0 (
    .clk(clk), .rst_n(rst_n), .cyc(cyc), .is_mem(is_mem), .wr(wr),
    .addr(addr), .wdata(wdata), .ram_lo_n(ram_lo_n), .ram_hi_n(ram_hi_n),
    .rom_n(rom_n), .dev_n(dev_n), .bank_n(bank_n)
  );

  // Vector order: {lo, hi, rom, dev, bank3..bank0}, active-low.
  function automatic logic [7:0] expv(input logic [19:0] a, input logic [1:0] b, input logic h);
    logic [7:0] v = 8'hFF;
    if (a < 20'h80000)       v[7] = 1'b0;
    else if (a >= 20'hE0000) v[5] = 1'b0;
    else if (a < 20'hA0000)  v[b] = 1'b0;
    else if (a < 20'hB0000)  v[4] = 1'b0;
    else if (a < 20'hC0000)  begin if (h) v[6] = 1'b0; end
    else                     begin if (h) v[6] = 1'b0; else v[5] = 1'b0; end
    return v;
  endfunction

  function automatic logic [7:0] got();
    return {ram_lo_n, ram_hi_n, rom_n, dev_n, bank_n};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b (addr %h)", req, act, exp, addr);
    end
  endtask

  task automatic bus(input logic c, input logic m, input logic w, input logic [19:0] a, input logic [1:0] d);
    @(negedge clk);
    cyc = c; is_mem = m; wr = w; addr = a; wdata = d;
  endtask

  task automatic mem_chk(input string req, input logic [19:0] a, input logic [1:0] b, input logic h);
    bus(1'b1, 1'b1, 1'b0, a, 2'b00);
    #1;
    check(req, got(), expv(a, b, h));
    checks++;
    if ($countones(~got()) > 1) begin
      fails++;
      $display("FAIL R10: %0d enables active, expected at most 1", $countones(~got()));
    end
  endtask

  task automatic io_wr(input logic [15:0] port, input logic [1:0] d);
    bus(1'b1, 1'b0, 1'b1, {4'h0, port}, d);
    #1;
    check("R1", got(), 8'hFF);   // I/O write cycle selects no memory
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #1;
    check("R1", got(), 8'hFF);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9: reset leaves bank 0 and ROM in the upper region
    mem_chk("R9", 20'h90000, 2'd0, 1'b0);
    mem_chk("R9", 20'hC1234, 2'd0, 1'b0);
    // R1: idle bus selects nothing
    bus(1'b0, 1'b1, 1'b0, 20'h12345, 2'b00); #1; check("R1", got(), 8'hFF);
    bus(1'b1, 1'b0, 1'b0, 20'h00000, 2'b00); #1; check("R1", got(), 8'hFF);

    // Full sweep over all bank/high-RAM settings, back-to-back after writes
    for (int h = 0; h < 2; h++) begin
      for (int b = 0; b < 4; b++) begin
        io_wr(16'h00F0, 2'(b));
        io_wr(16'h00F1, {1'b0, 1'(h)});
        for (int blk = 0; blk < 16; blk++) begin
          mem_chk("R2-R8", {4'(blk), 16'h0000}, 2'(b), 1'(h));
          mem_chk("R2-R8", {4'(blk), 16'h03FF}, 2'(b), 1'(h));
          mem_chk("R2-R8", {4'(blk), 16'hFFFF}, 2'(b), 1'(h));
        end
        mem_chk("R2", 20'h00000, 2'(b), 1'(h)); // vector table stays unbanked
      end
    end
    // State now: bank 3, high RAM on. R7: writes that must not load.
    bus(1'b1, 1'b0, 1'b0, 20'h000F0, 2'b01); // I/O read of bank port
    bus(1'b1, 1'b1, 1'b1, 20'h000F0, 2'b01); // memory write, same low bits
    bus(1'b1, 1'b0, 1'b1, 20'h000F2, 2'b01); // other port
    bus(1'b1, 1'b0, 1'b1, 20'h100F0, 2'b01); // upper bits ignored: loads
    mem_chk("R7", 20'h88000, 2'd1, 1'b1);
    bus(1'b1, 1'b0, 1'b0, 20'h000F0, 2'b10);
    mem_chk("R7", 20'h88000, 2'd1, 1'b1);
    // R8: turn high RAM off again; C/D back to ROM, B gap empty
    io_wr(16'h00F1, 2'b10);
    mem_chk("R8", 20'hD0000, 2'd1, 1'b0);
    mem_chk("R6", 20'hB8000, 2'd1, 1'b0);
    mem_chk("R5", 20'hA0001, 2'd1, 1'b0);
    mem_chk("R3", 20'hFFFF0, 2'd1, 1'b0);
    // R9: second reset mid-run
    rst_n = 1'b0; #1; rst_n = 1'b1;
    mem_chk("R9", 20'h9FFFF, 2'd0, 1'b0);
    mem_chk("R9", 20'hC0000, 2'd0, 1'b0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule